// File: doc/BRIEF.md
# Four-Row Nibble Store with Row Control Decoder

This block holds sixteen bits of data as four rows of four bits each. It has no clock. A two-bit row address, an active-low chip select and a single active-low write line go into a control decoder. For each row the decoder produces a write strobe and an output enable, both active low. Each row is a bank of edge-triggered cells that stores the shared input data on the rising edge of its own write strobe. A read path puts the contents of the enabled row onto the output data port.

The shared bidirectional data bus is split into three ports: an input path, an output path, and a drive-enable flag. The flag is high only while a selected read is in progress. A surrounding pad ring or bus fabric can use the flag to control a tri-state driver. The row strobes are also brought out as ports, so that the decoding can be observed directly. The data width and the row count are parameters.

Top module: `nibmem_core`

## Requirements
- R1: The row is picked by `addr` read as an unsigned binary number with bit 0 as its least significant bit: value 0 is row 0, 1 is row 1, 2 is row 2 and 3 is row 3. Bit `r` of `row_wr_n` and bit `r` of `row_oe_n` belong to row `r`.
- R2: While `cs_n` is 1, every bit of `row_wr_n` and `row_oe_n` is 1, `data_oe` is 0 and `data_out` is all zeros, whatever the values of `addr`, `we_n` and `data_in`.
- R3: With `cs_n`=0 and `we_n`=1, only the addressed bit of `row_oe_n` is 0 and all `row_wr_n` bits are 1. `data_oe` is 1 and `data_out` shows the stored contents of the addressed row without any clock delay.
- R4: With `cs_n`=0 and `we_n`=0, only the addressed bit of `row_wr_n` is 0. All `row_oe_n` bits are 1, `data_oe` is 0 and `data_out` is zero, so stored data never drives the bus during a write.
- R5: A row stores the value on `data_in` at the instant its strobe goes from 0 to 1. This happens when `we_n` rises while the row is selected. The value present when `we_n` fell, and any value held while `we_n` is low, is not stored.
- R6: No row ever has its write strobe and its output enable both at 0 at the same time. At most one row strobe of each kind is at 0.
- R7: A row keeps its contents through any activity in which it is not the addressed row, and through any `we_n` toggling while `cs_n` is 1.
- R8: All 16 combinations of the two address bits, `we_n` and `cs_n` give the pattern on the eight strobe outputs that R1 to R4 define.
- R9: If `cs_n` rises while `we_n` is 0, the write ends at that moment and the addressed row stores `data_in`. A later rise of `we_n` while `cs_n` is 1 stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 2 | Row address, bit 0 least significant |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write line, active low, stores data on its rising edge |
| data_in | input | 4 | Incoming half of the shared data bus |
| data_out | output | 4 | Outgoing half of the shared data bus, zero when not driving |
| data_oe | output | 1 | High while the block drives the bus (selected read) |
| row_wr_n | output | 4 | Decoded per-row write strobes, active low |
| row_oe_n | output | 4 | Decoded per-row output enables, active low |

## Verification
Every output is a combinational function of the inputs and the stored rows, so the decoded strobes, `data_oe` and `data_out` are due in the same bench step that changes the inputs. The bench drives on the falling edge of its pacing clock and samples a quarter period later, after the logic has settled and well before the next change. Storage is updated only by a rising strobe edge, which happens in the step where `we_n` or `cs_n` returns high. Each read-back therefore uses a separate step after that rise, and the bench holds `data_in` at the intended value across the step where the rise occurs.

// File: rtl/nibmem_pkg.sv
package nibmem_pkg;

   // Access kind seen by the control decoder
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_t;

   function automatic acc_kind_t classify(input logic cs_n, input logic we_n);
      if (cs_n)      return ACC_IDLE;
      else if (we_n) return ACC_READ;
      else           return ACC_WRITE;
   endfunction

endpackage

// File: rtl/nibmem_decode.sv
module nibmem_decode
   import nibmem_pkg::*;
#(
   parameter int ROWS = 4,
   localparam int ADDR_W = $clog2(ROWS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              cs_n,
   input  logic              we_n,
   output logic [ROWS-1:0]   wr_n,
   output logic [ROWS-1:0]   oe_n
);

   acc_kind_t kind;

   always_comb kind = classify(cs_n, we_n);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic hit;
      always_comb begin
         hit     = (addr == ADDR_W'(r));
         wr_n[r] = ~(hit && (kind == ACC_WRITE));
         oe_n[r] = ~(hit && (kind == ACC_READ));
      end
   end

endmodule

// File: rtl/nibmem_row.sv
module nibmem_row #(
   parameter int WIDTH = 4
) (
   input  logic             strobe_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   // Cells load on the return of the strobe from low to high
   always_ff @(posedge strobe_n) q <= d;

endmodule

// File: rtl/nibmem_rdpath.sv
module nibmem_rdpath #(
   parameter int ROWS  = 4,
   parameter int WIDTH = 4
) (
   input  logic [ROWS-1:0]            oe_n,
   input  logic [ROWS-1:0][WIDTH-1:0] rows,
   output logic [WIDTH-1:0]           dout,
   output logic                       drive
);

   logic [ROWS-1:0][WIDTH-1:0] gated;

   for (genvar r = 0; r < ROWS; r++) begin : g_gate
      always_comb gated[r] = oe_n[r] ? '0 : rows[r];
   end

   always_comb begin
      dout  = '0;
      drive = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
         dout  = dout | gated[r];
         drive = drive | ~oe_n[r];
      end
   end

endmodule

// File: rtl/nibmem_core.sv
module nibmem_core #(
   parameter int ROWS  = 4,
   parameter int WIDTH = 4,
   localparam int ADDR_W = $clog2(ROWS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic [WIDTH-1:0]  data_in,
   output logic [WIDTH-1:0]  data_out,
   output logic              data_oe,
   output logic [ROWS-1:0]   row_wr_n,
   output logic [ROWS-1:0]   row_oe_n
);

   if (ROWS < 2 || (1 << ADDR_W) != ROWS) begin : g_bad_rows
      $error("nibmem_core: ROWS must be a power of two and at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("nibmem_core: WIDTH must be at least 1");
   end

   logic [ROWS-1:0][WIDTH-1:0] store_q;

   nibmem_decode #(.ROWS(ROWS)) u_dec (
      .addr (addr),
      .cs_n (cs_n),
      .we_n (we_n),
      .wr_n (row_wr_n),
      .oe_n (row_oe_n)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_store
      nibmem_row #(.WIDTH(WIDTH)) u_row (
         .strobe_n (row_wr_n[r]),
         .d        (data_in),
         .q        (store_q[r])
      );
   end

   nibmem_rdpath #(.ROWS(ROWS), .WIDTH(WIDTH)) u_rd (
      .oe_n  (row_oe_n),
      .rows  (store_q),
      .dout  (data_out),
      .drive (data_oe)
   );

endmodule

// File: rtl/nibmem_core_chk.sv
module nibmem_core_chk #(
   parameter int ROWS  = 4,
   parameter int WIDTH = 4,
   localparam int ADDR_W = $clog2(ROWS)
) (
   input logic [ADDR_W-1:0] addr,
   input logic              cs_n,
   input logic              we_n,
   input logic [WIDTH-1:0]  data_out,
   input logic              data_oe,
   input logic [ROWS-1:0]   row_wr_n,
   input logic [ROWS-1:0]   row_oe_n
);

   always_comb begin
      // R6
      strobe_excl_chk: assert ((~row_wr_n & ~row_oe_n) == '0)
         else $error("row has write strobe and output enable active together");
      // R6
      one_writer_chk: assert ($onehot0(~row_wr_n))
         else $error("more than one write strobe active");
      // R2
      deselect_idle_chk: assert (!cs_n || (row_wr_n == '1 && row_oe_n == '1 && !data_oe))
         else $error("activity while chip select is high");
      // R3
      drive_onehot_chk: assert (data_oe == ($countones(~row_oe_n) == 1))
         else $error("bus drive flag disagrees with output enables");
      // R4
      write_quiet_chk: assert (cs_n || we_n || (!data_oe && data_out == '0))
         else $error("bus driven during a write");
      // R1
      row_match_chk: assert (cs_n || ((we_n ? ~row_oe_n : ~row_wr_n) == (ROWS'(1) << addr)))
         else $error("active strobe is not on the addressed row");
   end

endmodule

bind nibmem_core nibmem_core_chk #(.ROWS(ROWS), .WIDTH(WIDTH)) u_chk (
   .addr     (addr),
   .cs_n     (cs_n),
   .we_n     (we_n),
   .data_out (data_out),
   .data_oe  (data_oe),
   .row_wr_n (row_wr_n),
   .row_oe_n (row_oe_n)
);

// File: tb/nibmem_core_test.sv
module nibmem_core_test;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = CLK_PERIOD / 4;
   localparam int WDOG_LIMIT = 5000;

   logic       clk = 1'b0;
   logic [1:0] addr = '0;
   logic       cs_n = 1'b1;
   logic       we_n = 1'b1;
   logic [3:0] data_in = '0;
   logic [3:0] data_out;
   logic       data_oe;
   logic [3:0] row_wr_n;
   logic [3:0] row_oe_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [3:0] model [4];

   always #(CLK_PERIOD / 2) clk = ~clk;

   nibmem_core uut (
      .addr     (addr),
      .cs_n     (cs_n),
      .we_n     (we_n),
      .data_in  (data_in),
      .data_out (data_out),
      .data_oe  (data_oe),
      .row_wr_n (row_wr_n),
      .row_oe_n (row_oe_n)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WDOG_LIMIT) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WDOG_LIMIT);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Drive a step on the falling edge, then wait until settled
   task automatic step(input logic [1:0] a, input logic we, input logic cs, input logic [3:0] d);
      @(negedge clk);
      addr = a; we_n = we; cs_n = cs; data_in = d;
      #(SETTLE);
   endtask

   task automatic do_write(input logic [1:0] a, input logic [3:0] d);
      step(a, 1'b0, 1'b0, d);
      step(a, 1'b1, 1'b0, d);
      model[a] = d;
   endtask

   task automatic read_expect(input string req, input logic [1:0] a);
      step(a, 1'b1, 1'b0, 4'h0);
      chk(req, {11'd0, data_oe, data_out}, {11'd0, 1'b1, model[a]});
   endtask

   task automatic t_idle();
      step(2'd2, 1'b0, 1'b1, 4'hF);
      chk("R2 idle strobes", {8'd0, row_wr_n, row_oe_n}, 16'h00FF);
      chk("R2 idle bus", {11'd0, data_oe, data_out}, 16'h0000);
   endtask

   task automatic t_decode_sweep();
      for (int i = 0; i < 16; i++) begin
         logic [1:0] a;
         logic we, cs;
         logic [3:0] ew, eo;
         a = i[1:0]; we = i[2]; cs = i[3];
         step(a, we, cs, 4'h5);
         ew = 4'hF; eo = 4'hF;
         if (!cs && !we) ew[a] = 1'b0;
         if (!cs && we)  eo[a] = 1'b0;
         chk($sformatf("R8 combo %0d", i), {8'd0, row_wr_n, row_oe_n}, {8'd0, ew, eo});
         if (!cs && !we)
            chk("R4 no drive during write", {11'd0, data_oe, data_out}, 16'h0000);
         if (cs)
            chk("R2 deselected bus quiet", {11'd0, data_oe, data_out}, 16'h0000);
      end
      step(2'd0, 1'b1, 1'b1, 4'h0);
   endtask

   task automatic t_fill_and_read();
      logic [3:0] pat [3] = '{4'hA, 4'h3, 4'hC};
      for (int p = 0; p < 3; p++) begin
         for (int r = 0; r < 4; r++) do_write(2'(r), pat[p] ^ 4'(r));
         for (int r = 0; r < 4; r++) read_expect($sformatf("R1 R3 row %0d pat %0d", r, p), 2'(r));
      end
   endtask

   task automatic t_edge_capture();
      step(2'd1, 1'b0, 1'b0, 4'h6);   // fall with 6
      step(2'd1, 1'b0, 1'b0, 4'h9);   // hold low, value changes
      step(2'd1, 1'b1, 1'b0, 4'h9);   // rise with 9
      model[1] = 4'h9;
      read_expect("R5 rising edge value stored", 2'd1);
   endtask

   task automatic t_retention();
      for (int r = 0; r < 4; r++) do_write(2'(r), 4'(r + 1) * 4'h3);
      for (int k = 0; k < 3; k++) begin
         step(2'(k), 1'b0, 1'b1, 4'hE);
         step(2'(k), 1'b1, 1'b1, 4'hE);
      end
      for (int r = 0; r < 4; r++) read_expect($sformatf("R7 cs high retention row %0d", r), 2'(r));
      do_write(2'd2, 4'h0);
      do_write(2'd2, 4'hF);
      for (int r = 0; r < 4; r++) read_expect($sformatf("R7 other row retention row %0d", r), 2'(r));
   endtask

   task automatic t_cs_ends_write();
      step(2'd3, 1'b0, 1'b0, 4'h7);
      step(2'd3, 1'b0, 1'b1, 4'h7);   // cs rises first
      chk("R9 strobes idle after cs rise", {8'd0, row_wr_n, row_oe_n}, 16'h00FF);
      step(2'd3, 1'b1, 1'b1, 4'h2);   // we rises while deselected
      model[3] = 4'h7;
      read_expect("R9 cs-terminated write stored", 2'd3);
   endtask

   initial begin
      t_idle();
      t_decode_sweep();
      t_fill_and_read();
      t_edge_capture();
      t_retention();
      t_cs_ends_write();
      step(2'd0, 1'b1, 1'b1, 4'h0);
      summary();
      $finish;
   end

endmodule